// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This block decides, cycle by cycle, which of six regulator channels are allowed to run. Each channel has an active-low shutdown request: a request bit at 1 asks the rail to run and a 0 asks it to shut down. Comparators outside the block report three status flags. Rail 1 has passed its rise threshold (about 70 % of target). Rail 2 has passed its rise threshold (about 90 % of target). Rail 3 has dropped below its low threshold. A millisecond tick pulse supplies the timebase, and a protection-latch input, once asserted, turns everything off.

A mode input selects between two behaviours. With the mode input at 0 (sequenced), rail 1's request alone brings the first three rails up in order: rail 1, then rail 2, then rail 3 after a fixed delay. It takes them down in the reverse manner: rail 3 first, then rails 1 and 2 together. While rail 3 falls, a discharge switch enable is raised. With the mode input at 1 (independent), every rail follows its own request. In both modes no rail other than rail 1 may run while rail 1 is off.

Request, mode, status and protection inputs pass through two-flop synchronisers. The tick is taken as a one-cycle pulse that is already synchronous to the clock.

Top module: `rail_seq_ctrl`

## Requirements
- R1: During and after reset, all six rail enables and the discharge enable are 0, and the sequencer is in its all-off state.
- R2: With mode_indep=1, rail_en[i] equals run_req_n[i] for every rail, gated for rails 2..6 by rail 1's request (bit 0). A change appears within four clock cycles.
- R3: With mode_indep=0, request bits 1 and 2 (rails 2 and 3) are ignored. Raising bit 0 enables rail 1 alone among the first three rails. Rail 2 is enabled only after rail1_rise is seen high.
- R4: Rail 3 is enabled only after rail2_rise has been seen high and DLY_TICKS further tick pulses (default 3) have arrived. It is not enabled before the last of them.
- R5: Clearing bit 0 in sequenced mode drops rail 3 first. Rails 1 and 2 stay on until rail3_low is seen high, and then both drop in the same cycle.
- R6: The discharge enable is 1 exactly while the sequencer waits for rail 3 to fall. It is never 1 while rail 3 is enabled.
- R7: Rails 2..6 are never enabled while rail 1 is off, in either mode.
- R8: While prot_latch is high, all six rail enables are 0. After it is released with bit 0 still set in sequenced mode, the sequence restarts from rail 1.
- R9: A request withdrawn during power-up, before rail 3 is enabled, goes straight to the falling phase. Rail 3 stays off, discharge turns on, and the rails already on stay on until rail3_low.
- R10: In sequenced mode, rails 4..6 follow their own request bits (3..5), gated by rail 1 being enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req_n | input | 6 | Per-rail shutdown requests, active low (1 = run), bit 0 = rail 1 |
| mode_indep | input | 1 | 0 = sequenced, 1 = independent |
| rail1_rise | input | 1 | Rail 1 above its rise threshold |
| rail2_rise | input | 1 | Rail 2 above its rise threshold |
| rail3_low | input | 1 | Rail 3 below its low threshold |
| ms_tick | input | 1 | One-cycle timebase pulse, synchronous |
| prot_latch | input | 1 | Protection latch, forces all rails off |
| rail_en | output | 6 | Rail enables, bit 0 = rail 1 |
| rail3_dischg | output | 1 | Rail 3 output discharge enable |

## Verification
The assertions check on every cycle the properties that must hold in every state. Rails 2..6 stay off while rail 1 is off. The protection latch clears every enable. Discharge never overlaps rail 3 being on. Each sequenced enable or release follows the status flag or delay completion that permits it, and the tick counter stays in range. Other behaviours can only be shown by the bench's scenarios, because they depend on what the outputs are, not just on what they may never be. These are the exact order and timing of the full power-up and power-down, the ignoring of rail 2 and 3 requests in sequenced mode, the restart after the protection latch clears, and the jump to the falling phase on a mid-sequence withdrawal.

// File: rtl/rail_seq_pkg.sv
// Package: shared types for the rail sequencing controller.
// Assumes: rails 1..3 are the sequenced set; state encoding is free.
package rail_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_R1   = 3'd1,
        ST_R2   = 3'd2,
        ST_WAIT = 3'd3,
        ST_ON   = 3'd4,
        ST_FALL = 3'd5
    } seq_state_e;

    localparam int SEQ_RAILS = 3;
endpackage

// File: rtl/rail_sync2.sv
// Module: rail_sync2 - two-flop synchroniser for a bus of level signals.
// Assumes: each bit is an independent slow level; no bus coherency implied.
module rail_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_out  <= '0;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/rail_tick_timer.sv
// Module: rail_tick_timer - counts timebase ticks while run is high.
// Assumes: tick is a one-cycle synchronous pulse; DLY_TICKS >= 1.
// done pulses on the tick that completes DLY_TICKS ticks.
module rail_tick_timer #(
    parameter int DLY_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (DLY_TICKS < 2) ? 1 : $clog2(DLY_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Completion flag: the final tick of the window.
    always_comb begin
        done = run && tick && (cnt_q == LAST);
    end

    // Tick counter, cleared whenever the timer is not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    tick_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rail_seq_fsm.sv
// Module: rail_seq_fsm - ordered up/down sequencer for rails 1..3.
// Assumes: inputs are synchronised; active=0 (independent mode or
// protection) forces the all-off state immediately.
module rail_seq_fsm
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       go,
    input  logic       up1,
    input  logic       up2,
    input  logic       low3,
    input  logic       dly_done,
    output logic       timer_run,
    output logic [2:0] seq_en,
    output logic       dischg
);
    seq_state_e state_q;
    logic en1_q, en2_q, en3_q;

    // State and held enables; rails 1/2 persist through the falling phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= ST_OFF;
            en1_q   <= 1'b0;
            en2_q   <= 1'b0;
            en3_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (go) begin
                        en1_q   <= 1'b1;
                        state_q <= ST_R1;
                    end
                end
                ST_R1: begin
                    if (!go) begin
                        state_q <= ST_FALL;
                    end else if (up1) begin
                        en2_q   <= 1'b1;
                        state_q <= ST_R2;
                    end
                end
                ST_R2: begin
                    if (!go) begin
                        state_q <= ST_FALL;
                    end else if (up2) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!go) begin
                        state_q <= ST_FALL;
                    end else if (dly_done) begin
                        en3_q   <= 1'b1;
                        state_q <= ST_ON;
                    end
                end
                ST_ON: begin
                    if (!go) begin
                        en3_q   <= 1'b0;
                        state_q <= ST_FALL;
                    end
                end
                ST_FALL: begin
                    if (low3) begin
                        en1_q   <= 1'b0;
                        en2_q   <= 1'b0;
                        state_q <= ST_OFF;
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    // Decoded outputs of the held state.
    always_comb begin
        seq_en    = {en3_q, en2_q, en1_q};
        dischg    = (state_q == ST_FALL);
        timer_run = (state_q == ST_WAIT);
    end

    // R3
    r3_rail2_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en2_q) |-> $past(up1));
    // R4
    r4_rail3_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en3_q) |-> $past(dly_done));
    // R5
    r5_pair_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(en1_q) && $past(active)) |-> ($past(low3) && !en2_q));
    // R6
    r6_dischg_rail3_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dischg |-> !en3_q);
endmodule

// File: rtl/rail_enable_mux.sv
// Module: rail_enable_mux - final enable gating for all rails.
// Assumes: inputs synchronised; rail 1 gates every other rail; protection
// overrides everything.
module rail_enable_mux #(
    parameter int NUM_RAILS = 6
) (
    input  logic                 indep,
    input  logic                 fault,
    input  logic [NUM_RAILS-1:0] req,
    input  logic [2:0]           seq_en,
    output logic [NUM_RAILS-1:0] rail_en
);
    logic rail1_on;

    // Rail 1 source selection with protection override.
    always_comb begin
        rail1_on = !fault && (indep ? req[0] : seq_en[0]);
    end

    assign rail_en[0] = rail1_on;

    for (genvar i = 1; i < NUM_RAILS; i++) begin : g_rail
        if (i < rail_seq_pkg::SEQ_RAILS) begin : g_seq
            // Sequenced rails take the sequencer's enable outside independent mode.
            assign rail_en[i] = rail1_on && (indep ? req[i] : seq_en[i]);
        end else begin : g_free
            // Free rails always follow their own request.
            assign rail_en[i] = rail1_on && req[i];
        end
    end
endmodule

// File: rtl/rail_seq_ctrl.sv
// Module: rail_seq_ctrl - top of the six-rail enable controller.
// Assumes: ms_tick is synchronous; all other inputs are asynchronous levels
// and are synchronised here. NUM_RAILS >= 4.
module rail_seq_ctrl #(
    parameter int NUM_RAILS = 6,
    parameter int DLY_TICKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] run_req_n,
    input  logic                 mode_indep,
    input  logic                 rail1_rise,
    input  logic                 rail2_rise,
    input  logic                 rail3_low,
    input  logic                 ms_tick,
    input  logic                 prot_latch,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 rail3_dischg
);
    localparam int SW = NUM_RAILS + 5;

    logic [SW-1:0]        sync_q;
    logic [NUM_RAILS-1:0] req_s;
    logic                 mode_s, fault_s, up1_s, up2_s, low3_s;
    logic                 seq_active, timer_run, dly_done;
    logic [2:0]           seq_en;

    rail_sync2 #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({prot_latch, mode_indep, rail3_low, rail2_rise, rail1_rise, run_req_n}),
        .d_out (sync_q)
    );

    // Unpack the synchronised bus.
    always_comb begin
        req_s      = sync_q[NUM_RAILS-1:0];
        up1_s      = sync_q[NUM_RAILS];
        up2_s      = sync_q[NUM_RAILS+1];
        low3_s     = sync_q[NUM_RAILS+2];
        mode_s     = sync_q[NUM_RAILS+3];
        fault_s    = sync_q[NUM_RAILS+4];
        seq_active = !mode_s && !fault_s;
    end

    rail_tick_timer #(.DLY_TICKS(DLY_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (ms_tick),
        .done  (dly_done)
    );

    rail_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (seq_active),
        .go        (req_s[0]),
        .up1       (up1_s),
        .up2       (up2_s),
        .low3      (low3_s),
        .dly_done  (dly_done),
        .timer_run (timer_run),
        .seq_en    (seq_en),
        .dischg    (rail3_dischg)
    );

    rail_enable_mux #(.NUM_RAILS(NUM_RAILS)) u_mux (
        .indep   (mode_s),
        .fault   (fault_s),
        .req     (req_s),
        .seq_en  (seq_en),
        .rail_en (rail_en)
    );

    // R7
    r7_rail1_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_en[0] |-> (rail_en[NUM_RAILS-1:1] == '0));
    // R8
    r8_prot_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_s |-> (rail_en == '0));
    // R6
    r6_no_dischg_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |=> !rail3_dischg);
endmodule

// File: tb/tb_rail_seq_ctrl.sv
module tb_rail_seq_ctrl;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] run_req_n = '0;
    logic         mode_indep = 1'b0;
    logic         rail1_rise = 1'b0;
    logic         rail2_rise = 1'b0;
    logic         rail3_low = 1'b1;
    logic         ms_tick = 1'b0;
    logic         prot_latch = 1'b0;
    logic [N-1:0] rail_en;
    logic         rail3_dischg;

    int vectors = 0;
    int misses = 0;

    always #4 clk = ~clk;

    rail_seq_ctrl #(.NUM_RAILS(N), .DLY_TICKS(3)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_req_n    (run_req_n),
        .mode_indep   (mode_indep),
        .rail1_rise   (rail1_rise),
        .rail2_rise   (rail2_rise),
        .rail3_low    (rail3_low),
        .ms_tick      (ms_tick),
        .prot_latch   (prot_latch),
        .rail_en      (rail_en),
        .rail3_dischg (rail3_dischg)
    );

    // Independent-mode table: {prot, request[5:0], expected enables[5:0]}
    localparam logic [12:0] VEC [8] = '{
        13'b0_111111_111111,
        13'b0_111110_000000,
        13'b0_000001_000001,
        13'b0_101011_101011,
        13'b0_010101_010101,
        13'b1_111111_000000,
        13'b0_100001_100001,
        13'b0_011110_000000
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_en(input string tag, input logic [N-1:0] exp);
        vectors++;
        if (rail_en !== exp) begin
            misses++;
            $display("FAIL %s rail_en act=%b exp=%b", tag, rail_en, exp);
        end
    endtask

    task automatic chk_dis(input string tag, input logic exp);
        vectors++;
        if (rail3_dischg !== exp) begin
            misses++;
            $display("FAIL %s rail3_dischg act=%b exp=%b", tag, rail3_dischg, exp);
        end
    endtask

    task automatic pulse_tick();
        ms_tick = 1'b1;
        step(1);
        ms_tick = 1'b0;
        step(2);
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        step(3);
        chk_en("R1 in reset", '0);
        chk_dis("R1 in reset", 1'b0);
        rst_n = 1'b1;
        step(4);
        chk_en("R1 after reset", '0);
        chk_dis("R1 after reset", 1'b0);

        // R2: independent mode table walk
        mode_indep = 1'b1;
        for (int k = 0; k < 8; k++) begin
            prot_latch = VEC[k][12];
            run_req_n  = VEC[k][11:6];
            step(4);
            chk_en("R2 R7 R8 indep vector", VEC[k][5:0]);
        end
        prot_latch = 1'b0;
        run_req_n  = '0;
        mode_indep = 1'b0;
        step(4);
        chk_en("R1 idle sequenced", '0);

        // R3 R10: sequenced power-up, bits 1,2 cleared yet rails 2,3 still come up
        rail3_low = 1'b1;
        run_req_n = 6'b001001;
        step(4);
        chk_en("R3 R10 rail1 first", 6'b001001);
        step(4);
        chk_en("R3 rail2 waits rise", 6'b001001);
        rail1_rise = 1'b1;
        step(4);
        chk_en("R3 rail2 on", 6'b001011);
        rail2_rise = 1'b1;
        rail3_low  = 1'b0;
        step(4);
        chk_en("R4 no rail3 before ticks", 6'b001011);
        pulse_tick();
        pulse_tick();
        chk_en("R4 two ticks not enough", 6'b001011);
        pulse_tick();
        step(1);
        chk_en("R4 rail3 after third tick", 6'b001111);
        chk_dis("R6 off while rail3 on", 1'b0);

        // R5 R6: power-down
        run_req_n = 6'b001000;
        step(4);
        chk_en("R5 rail3 drops first", 6'b001011);
        chk_dis("R6 discharge while falling", 1'b1);
        step(6);
        chk_en("R5 rails 1,2 held", 6'b001011);
        rail3_low = 1'b1;
        step(4);
        chk_en("R5 R7 pair released", 6'b000000);
        chk_dis("R6 discharge ends", 1'b0);

        // R9: withdrawal during power-up
        rail1_rise = 1'b0;
        rail2_rise = 1'b0;
        rail3_low  = 1'b0;
        run_req_n  = 6'b000001;
        step(4);
        chk_en("R9 restart rail1", 6'b000001);
        rail1_rise = 1'b1;
        step(4);
        chk_en("R9 rail2 up", 6'b000011);
        run_req_n = 6'b000110;
        step(4);
        chk_en("R9 held while falling", 6'b000011);
        chk_dis("R9 discharge on", 1'b1);
        rail3_low = 1'b1;
        step(4);
        chk_en("R9 released", 6'b000000);
        chk_dis("R9 discharge off", 1'b0);

        // R8: protection during sequenced operation, then restart
        run_req_n  = 6'b111111;
        rail1_rise = 1'b1;
        rail2_rise = 1'b0;
        step(6);
        chk_en("R8 before latch", 6'b111011);
        prot_latch = 1'b1;
        step(4);
        chk_en("R8 latch forces off", 6'b000000);
        chk_dis("R8 no discharge", 1'b0);
        prot_latch = 1'b0;
        step(7);
        chk_en("R8 restart after release", 6'b111011);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule